// File: doc/BRIEF.md
# Paged Word Collector with Wrapping Slot Pointer

This block gathers the data words of a multi-word programming instruction for a word-organised non-volatile array. A collection opens on a start strobe that carries a 10-bit word address. The upper seven address bits select a page and stay fixed. The lower three bits give the slot that receives the first word. Each accepted word goes into the current slot of an eight-entry buffer and sets that slot's valid bit. The slot pointer then advances and wraps inside the page, so a ninth or later word replaces an earlier one.

The serial front end reports four kinds of event, each as a one-cycle strobe. A word-complete strobe carries a word. Every serial clock rising edge produces a strobe. A chip-select rise ends the instruction.

The collected words are handed to the programming controller only when chip select rises in the short window after the last data bit. That window closes at the next serial clock rising edge. A commit is also refused if writes were not enabled when the instruction started, or if the hardware lock input was high at any point during the instruction. On a commit the block raises a registered one-cycle request that gives the page number and a mask of the slots that hold received words. The controller then fetches each word through a registered read port.

Top module: `page_wrbuf`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `commit_vld` is 0 and `commit_page`, `commit_mask` and `rd_word` are all zero.
- R2: After a start with address A, the first accepted word is stored in slot A[2:0], not slot 0. Slot s can be read on `rd_word` one cycle after `rd_slot` is set to s.
- R3: Each accepted word advances the slot pointer by one. The pointer wraps from 7 to 0. The page, A[9:3], does not change during the collection.
- R4: Words beyond eight overwrite earlier slots in order. Starting at slot 0 with ten words, slot 0 holds the ninth word and slot 1 holds the tenth.
- R5: Bit i of the committed mask is 1 exactly when slot i received a word since the latest start. A start clears all valid bits.
- R6: A `cs_rise` during a collection ends the collection. If the window is open, the collection is allowed and at least one word was accepted, `commit_vld` pulses high for one cycle in the cycle after `cs_rise`, together with the page and the mask. The window is open when a word was accepted and no `sk_rise` has come since.
- R7: If `sk_rise` arrives after the last word, or if no word was accepted, a later `cs_rise` ends the collection without a commit.
- R8: `sk_rise` in the same cycle as `cs_rise` prevents a commit. `sk_rise` in the same cycle as `word_vld` leaves the window open.
- R9: There is no commit if `wr_enabled` was low in the start cycle. There is also no commit if `wr_lock` was high in any cycle from the start through the `cs_rise` cycle.
- R10: `word_vld` outside a collection, or in the same cycle as `cs_rise`, stores nothing and sets no valid bit.
- R11: `commit_page` and `commit_mask` keep their last committed values until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a collection (takes priority over every other strobe) |
| start_addr | input | 10 | Word address given with `start` |
| wr_enabled | input | 1 | Write-enable state, sampled with `start` |
| wr_lock | input | 1 | Hardware lock level; high blocks the commit |
| word_vld | input | 1 | A full data word has been received |
| word_data | input | 16 | Data word for `word_vld` |
| sk_rise | input | 1 | Strobe for each serial clock rising edge |
| cs_rise | input | 1 | Strobe for the chip-select rising edge |
| rd_slot | input | 3 | Slot to read |
| commit_vld | output | 1 | One-cycle commit request |
| commit_page | output | 7 | Page of the commit |
| commit_mask | output | 8 | Slots holding received words |
| rd_word | output | 16 | Registered read data |

## Verification
Several strobes can arrive in the same cycle, and three such collisions are provoked on purpose. A `cs_rise` together with `sk_rise` must lose the commit. A `word_vld` together with `sk_rise` must still open the window. A `word_vld` together with `cs_rise` must be dropped: the mask it produces and a read of the slot it would have written both show that. A behavioural reference model applies the same priority rules from the requirements and is compared with the outputs on every clock. Wrap-around and overwrite are judged from the slot contents read back through the read port.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    S_IDLE = 1'b0,
    S_FILL = 1'b1
  } pwb_state_e;
endpackage

// File: rtl/pwb_ptr.sv
module pwb_ptr #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_WORDS = 8,
  localparam int SLOT_W    = $clog2(PAGE_WORDS),
  localparam int PAGE_W    = ADDR_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              accept,
  input  logic              sk_rise,
  output logic [SLOT_W-1:0] ptr,
  output logic [PAGE_W-1:0] page,
  output logic [PAGE_WORDS-1:0] mask,
  output logic              win
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      page <= '0;
      win  <= 1'b0;
    end else if (start) begin
      ptr  <= start_addr[SLOT_W-1:0];
      page <= start_addr[ADDR_W-1:SLOT_W];
      win  <= 1'b0;
    end else if (accept) begin
      ptr <= ptr + 1'b1;
      win <= 1'b1;
    end else if (sk_rise) begin
      win <= 1'b0;
    end
  end

  for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || start) mask[g] <= 1'b0;
      else if (accept && ptr == SLOT_W'(g)) mask[g] <= 1'b1;
    end
  end

  p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
    accept && !start |=> $stable(page));
  p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
    accept && !start |=> mask[$past(ptr)]);
  p_mask_clr_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> mask == '0);
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 8,
  localparam int SLOT_W    = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [PAGE_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wr_enabled,
  input  logic wr_lock,
  input  logic word_vld,
  input  logic sk_rise,
  input  logic cs_rise,
  input  logic win,
  input  logic mask_any,
  output logic accept,
  output logic commit_now
);
  pwb_state_e state;
  logic       bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      bad   <= 1'b0;
    end else if (start) begin
      state <= S_FILL;
      bad   <= !wr_enabled || wr_lock;
    end else if (state == S_FILL) begin
      if (cs_rise) state <= S_IDLE;
      if (wr_lock) bad <= 1'b1;
    end
  end

  always_comb begin
    accept     = (state == S_FILL) && !start && word_vld && !cs_rise;
    commit_now = (state == S_FILL) && !start && cs_rise && win && !bad &&
                 !wr_lock && !sk_rise && mask_any;
  end

  p_fill_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_FILL) && cs_rise && !start |=> state == S_IDLE);
  p_idle_no_store_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) && !start |-> !accept);
endmodule

// File: rtl/page_wrbuf.sv
module page_wrbuf #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 8,
  localparam int SLOT_W    = $clog2(PAGE_WORDS),
  localparam int PAGE_W    = ADDR_W - SLOT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic                  wr_enabled,
  input  logic                  wr_lock,
  input  logic                  word_vld,
  input  logic [DATA_W-1:0]     word_data,
  input  logic                  sk_rise,
  input  logic                  cs_rise,
  input  logic [SLOT_W-1:0]     rd_slot,
  output logic                  commit_vld,
  output logic [PAGE_W-1:0]     commit_page,
  output logic [PAGE_WORDS-1:0] commit_mask,
  output logic [DATA_W-1:0]     rd_word
);
  logic                  accept, commit_now, win;
  logic [SLOT_W-1:0]     ptr;
  logic [PAGE_W-1:0]     page;
  logic [PAGE_WORDS-1:0] mask;

  pwb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .wr_enabled(wr_enabled),
    .wr_lock(wr_lock), .word_vld(word_vld), .sk_rise(sk_rise),
    .cs_rise(cs_rise), .win(win), .mask_any(|mask),
    .accept(accept), .commit_now(commit_now)
  );

  pwb_ptr #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_ptr (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .accept(accept), .sk_rise(sk_rise), .ptr(ptr), .page(page),
    .mask(mask), .win(win)
  );

  pwb_store #(.DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)) u_store (
    .clk(clk), .rst(rst), .we(accept), .waddr(ptr), .wdata(word_data),
    .raddr(rd_slot), .rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_vld  <= 1'b0;
      commit_page <= '0;
      commit_mask <= '0;
    end else begin
      commit_vld <= commit_now;
      if (commit_now) begin
        commit_page <= page;
        commit_mask <= mask;
      end
    end
  end

  p_commit_cause_r6: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> $past(cs_rise));
  p_commit_clk_r8: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> !$past(sk_rise));
  p_commit_lock_r9: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> !$past(wr_lock));
  p_commit_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> commit_mask != '0);
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    commit_vld |=> !commit_vld);
  p_commit_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !commit_vld |-> $stable(commit_mask) && $stable(commit_page));
endmodule

// File: tb/page_wrbuf_tb_top.sv
module page_wrbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 0, wr_enabled = 0, wr_lock = 0, word_vld = 0;
  logic        sk_rise = 0, cs_rise = 0;
  logic [9:0]  start_addr = '0;
  logic [15:0] word_data = '0;
  logic [2:0]  rd_slot = '0;
  logic        commit_vld;
  logic [6:0]  commit_page;
  logic [7:0]  commit_mask;
  logic [15:0] rd_word;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #10 clk = ~clk;

  page_wrbuf dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .wr_enabled(wr_enabled), .wr_lock(wr_lock), .word_vld(word_vld),
    .word_data(word_data), .sk_rise(sk_rise), .cs_rise(cs_rise),
    .rd_slot(rd_slot), .commit_vld(commit_vld), .commit_page(commit_page),
    .commit_mask(commit_mask), .rd_word(rd_word)
  );

  // behavioural reference model
  bit  m_fill, m_win, m_bad, m_vld;
  int  m_ptr, m_page, m_mask, m_cpage, m_cmask, m_rd;
  int  m_mem [8];
  bit  m_known [8];
  bit  m_rd_known;

  always @(posedge clk) begin
    if (rst) begin
      m_fill = 0; m_win = 0; m_bad = 0; m_vld = 0; m_ptr = 0; m_page = 0;
      m_mask = 0; m_cpage = 0; m_cmask = 0; m_rd = 0; m_rd_known = 1;
    end else begin
      m_rd_known = m_known[rd_slot];
      m_rd = m_mem[rd_slot];
      m_vld = 0;
      if (start) begin
        m_fill = 1; m_page = start_addr / 8; m_ptr = start_addr % 8;
        m_mask = 0; m_win = 0; m_bad = !wr_enabled || wr_lock;
      end else if (m_fill) begin
        if (wr_lock) m_bad = 1;
        if (cs_rise) begin
          m_fill = 0;
          if (m_win && !m_bad && !sk_rise && m_mask != 0) begin
            m_vld = 1; m_cpage = m_page; m_cmask = m_mask;
          end
        end else if (word_vld) begin
          m_mem[m_ptr] = word_data; m_known[m_ptr] = 1;
          m_mask = m_mask | (1 << m_ptr);
          m_ptr = (m_ptr + 1) % 8; m_win = 1;
        end else if (sk_rise) m_win = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (commit_vld !== m_vld || commit_page !== 7'(m_cpage) ||
          commit_mask !== 8'(m_cmask) ||
          (m_rd_known && rd_word !== 16'(m_rd))) begin
        errors++;
        $display("FAIL %s model: vld/page/mask/rd act %0d/%h/%h/%h exp %0d/%h/%h/%h",
                 cur_req, commit_vld, commit_page, commit_mask, rd_word,
                 m_vld, m_cpage, m_cmask, m_rd);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_start(input logic [9:0] a, input logic en);
    start = 1; start_addr = a; wr_enabled = en; tick(); start = 0;
  endtask

  task automatic do_word(input logic [15:0] d, input logic with_sk);
    word_vld = 1; word_data = d; sk_rise = with_sk; tick();
    word_vld = 0; sk_rise = 0; tick();
  endtask

  task automatic do_sk(); sk_rise = 1; tick(); sk_rise = 0; endtask

  task automatic do_cs(input logic with_sk, input logic with_word, input logic [15:0] d);
    cs_rise = 1; sk_rise = with_sk; word_vld = with_word; word_data = d; tick();
    cs_rise = 0; sk_rise = 0; word_vld = 0;
  endtask

  task automatic rd(input int slot, input int exp, input string req);
    rd_slot = 3'(slot); tick(); chk(req, rd_word, exp);
  endtask

  initial begin
    repeat (3) tick();
    cur_req = "R1";
    chk("R1", commit_vld, 0); chk("R1", commit_mask, 0);
    chk("R1", commit_page, 0); chk("R1", rd_word, 0);
    rst = 0; tick();
    chk("R1", commit_vld, 0);

    // R2 / R3: start mid-page, three words, close in window
    cur_req = "R2";
    do_start(10'h2A5, 1);
    do_word(16'hA005, 0); do_sk();
    do_word(16'hA006, 0); do_sk();
    do_word(16'hA007, 0);
    do_cs(0, 0, 0);
    chk("R6", commit_vld, 1); chk("R3", commit_page, 'h54); chk("R5", commit_mask, 'hE0);
    tick(); chk("R6", commit_vld, 0);
    rd(5, 'hA005, "R2"); rd(7, 'hA007, "R2");

    // R3: wrap from 7 to 0
    cur_req = "R3";
    do_start(10'h0F6, 1);
    for (int i = 0; i < 4; i++) do_word(16'hB000 + 16'(i), 1);
    do_cs(0, 0, 0);
    chk("R3", commit_mask, 'hC3); chk("R3", commit_page, 'h1E);
    rd(0, 'hB002, "R3"); rd(1, 'hB003, "R3");

    // R4: ten words overwrite slots 0 and 1
    cur_req = "R4";
    do_start(10'h100, 1);
    for (int i = 0; i < 10; i++) do_word(16'h1000 + 16'(i), 1);
    do_cs(0, 0, 0);
    chk("R4", commit_mask, 'hFF); chk("R4", commit_page, 'h20);
    rd(0, 'h1008, "R4"); rd(1, 'h1009, "R4"); rd(2, 'h1002, "R4");

    // R7: serial clock after last word closes the window
    cur_req = "R7";
    do_start(10'h3F8, 1);
    do_word(16'hC000, 0); do_sk();
    do_cs(0, 0, 0);
    chk("R7", commit_vld, 0);
    chk("R11", commit_page, 'h20); chk("R11", commit_mask, 'hFF);
    do_start(10'h3F8, 1); do_cs(0, 0, 0);
    chk("R7", commit_vld, 0);

    // R8: collisions
    cur_req = "R8";
    do_start(10'h011, 1);
    do_word(16'hD001, 0);
    do_cs(1, 0, 0);
    chk("R8", commit_vld, 0);
    do_start(10'h011, 1);
    do_word(16'hD002, 1);
    do_cs(0, 0, 0);
    chk("R8", commit_vld, 1); chk("R8", commit_mask, 'h02);

    // R9: write disabled, then lock pulse mid-instruction
    cur_req = "R9";
    do_start(10'h020, 0);
    do_word(16'hE000, 0); do_cs(0, 0, 0);
    chk("R9", commit_vld, 0);
    do_start(10'h020, 1);
    do_word(16'hE001, 0);
    wr_lock = 1; tick(); wr_lock = 0;
    do_word(16'hE002, 0); do_cs(0, 0, 0);
    chk("R9", commit_vld, 0);
    chk("R11", commit_mask, 'h02);

    // R10: stray word outside collection and word with cs_rise
    cur_req = "R10";
    do_word(16'hF0F0, 0);
    do_start(10'h002, 1);
    do_word(16'hF002, 0);
    do_cs(0, 1, 16'hF003);
    chk("R10", commit_vld, 1); chk("R10", commit_mask, 'h04);
    rd(3, 'h1003, "R10");
    rd(2, 'hF002, "R10");

    repeat (3) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule